// File: doc/BRIEF.md
# Serial Port Register Front-End with Receive Queue

This block is the processor-facing register set of a serial port. It queues received characters in a small FIFO and reports queue and transmit state through a flag word. It keeps the divisor and line-format settings that the serial engine needs. It raises a single interrupt line from a raw / enable / masked / write-one-to-clear interrupt bank. Characters arrive from the serial engine through a valid/ready pair. A processor write to the data word hands one character to the transmit side through a one-cycle strobe.

The processor reaches the block through a simple single-cycle register port over a 4 KB window, addressed by byte with word-aligned accesses. Read data is combinational while the read strobe is high. A read of the data word removes the head entry of the queue on the clock edge that ends the access. Line-control bit 4 selects between a 16-deep queue and a single-entry holding register. The top 32 bytes of the window return a fixed identification byte sequence.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the flag word (offset 0x18) reads 0x90, the control word (0x30) reads 0x300, the level-select word (0x34) reads 0x12, the interrupt enable word (0x38) reads 0, `irq` is low and `rx_ready` is high. Flag bits: 7 = transmit empty (always 1), 6 = receive full, 5 = transmit full (always 0), 4 = receive empty.
- R2: With line-control (offset 0x2C) bit 4 set, `rx_ready` is high while fewer than 16 characters are held, and characters are returned in arrival order, including across pointer wrap.
- R3: With line-control bit 4 clear, `rx_ready` is high only when the queue is empty, so at most one character is held, and an offered character is dropped while it is low.
- R4: Flag bit 6 is set while the held count is at least the active capacity (16, or 1 in single-entry mode), and clears after a pop.
- R5: A read of offset 0x00 returns the head character in bits 7:0 and pops it. Flag bit 4 is set when the count becomes zero. A read of offset 0x00 when the queue is empty changes neither the count nor the pointers.
- R6: Raw interrupt bit 4 (receive) sets when an accepted character brings the count to 1. It clears when a pop brings the count to 0, or when 1 is written to bit 4 of the clear word (offset 0x44).
- R7: A write to offset 0x00 drives `tx_valid` high in that cycle with `tx_data` equal to write-data bits 7:0, and sets raw interrupt bit 5 (transmit).
- R8: Offset 0x38 is the 11-bit interrupt enable, 0x3C the raw status, 0x40 the masked status (raw AND enable). Writing ones to offset 0x44 clears those raw bits. `irq` is the OR of the masked bits. When a bit is set and cleared in the same cycle, the set wins.
- R9: Byte offsets 0xFE0, 0xFE4, … 0xFFC read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Settings read back as written, truncated to their widths: low-power divisor 0x20 (8 bits), integer divisor 0x24 (16), fractional divisor 0x28 (6), line control 0x2C (8), control 0x30 (16), level select 0x34 (6). Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data word) |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Queue can take the offered character |
| tx_valid | output | 1 | Transmit character strobe |
| tx_data | output | 8 | Transmit character |
| irq | output | 1 | Combined interrupt request |

## Verification
The queue is filled to its limit and drained with an arithmetic byte sequence, which separates ordering faults from pointer-wrap faults. A second fill after a partial drain forces the pointers across the end of storage. The same traffic in single-entry mode shows whether the capacity and full-flag logic follows line control. Pops from an empty queue, offers while not ready, and a clear that coincides with a set show whether stale reads, dropped characters and set/clear priority are handled as required. A sweep over every identification word and every settings word, using all-ones and alternating data, separates decode faults from width faults.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int ADDR_W = 12;
   localparam int WORD_W = ADDR_W - 2;
   localparam int BUS_W  = 32;

   localparam logic [WORD_W-1:0] OFS_DATA  = 10'd0;
   localparam logic [WORD_W-1:0] OFS_FLAG  = 10'd6;
   localparam logic [WORD_W-1:0] OFS_LPDIV = 10'd8;
   localparam logic [WORD_W-1:0] OFS_IBAUD = 10'd9;
   localparam logic [WORD_W-1:0] OFS_FBAUD = 10'd10;
   localparam logic [WORD_W-1:0] OFS_LINE  = 10'd11;
   localparam logic [WORD_W-1:0] OFS_CTRL  = 10'd12;
   localparam logic [WORD_W-1:0] OFS_LEVEL = 10'd13;
   localparam logic [WORD_W-1:0] OFS_MASK  = 10'd14;
   localparam logic [WORD_W-1:0] OFS_RAW   = 10'd15;
   localparam logic [WORD_W-1:0] OFS_MIS   = 10'd16;
   localparam logic [WORD_W-1:0] OFS_CLR   = 10'd17;

   localparam int FLG_TXE = 7;
   localparam int FLG_RXF = 6;
   localparam int FLG_TXF = 5;
   localparam int FLG_RXE = 4;

   localparam int IRQ_RX = 4;
   localparam int IRQ_TX = 5;

   localparam int LINE_FIFO_EN = 4;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0:    id_byte = 8'h11;
         3'd1:    id_byte = 8'h10;
         3'd2:    id_byte = 8'h14;
         3'd3:    id_byte = 8'h00;
         3'd4:    id_byte = 8'h0D;
         3'd5:    id_byte = 8'hF0;
         3'd6:    id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/sp_rx_fifo.sv
module sp_rx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [DATA_W-1:0]           push_data,
   input  logic                        pop,
   output logic [DATA_W-1:0]           pop_data,
   output logic [$clog2(DEPTH+1)-1:0]  count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sp_rx_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sp_rx_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic              pop_ok;

   assign pop_ok = pop && (count != '0);

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_ptr_nx = PTR_W'(wr_ptr + 1'b1);
      assign rd_ptr_nx = PTR_W'(rd_ptr + 1'b1);
   end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : PTR_W'(wr_ptr + 1'b1);
      assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : PTR_W'(rd_ptr + 1'b1);
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push)   wr_ptr <= wr_ptr_nx;
         if (pop_ok) rd_ptr <= rd_ptr_nx;
         case ({push, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign pop_data = mem[rd_ptr];

   // R2: the front end never offers a character to a full queue
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < FULL_CNT));

   // R5: popping an empty queue leaves count and read pointer alone
   p_empty_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && count == '0) |=> (count == '0 && $stable(rd_ptr)));
endmodule

// File: rtl/sp_irq_bank.sv
module sp_irq_bank #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wdata,
   output logic [W-1:0] raw,
   output logic [W-1:0] mask,
   output logic [W-1:0] masked,
   output logic         irq
);
   if (W < 6) begin : g_bad_w
      $error("sp_irq_bank: W must cover the transmit bit");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          raw[i] <= 1'b0;
         else if (set_vec[i]) raw[i] <= 1'b1;
         else if (clr_vec[i]) raw[i] <= 1'b0;
      end

      // R6: a set request is visible in the raw word next cycle
      p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> raw[i]);

      // R8: a clear with no coincident set drops the raw bit
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !raw[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wdata;
   end

   assign masked = raw & mask;
   assign irq    = |masked;
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
   import sp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int TRIG      = 1,
   parameter int IRQ_W     = 11,
   parameter int LPDIV_W   = 8,
   parameter int IBAUD_W   = 16,
   parameter int FBAUD_W   = 6,
   parameter int LINE_W    = 8,
   parameter int CTRL_W    = 16,
   parameter int LEVEL_W   = 6,
   parameter int CTRL_RST  = 'h300,
   parameter int LEVEL_RST = 'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [11:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq
);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG);

   if (DATA_W != 8) begin : g_bad_data
      $error("serial_port_regs: character ports are 8 bits");
   end
   if (TRIG < 1 || TRIG > DEPTH) begin : g_bad_trig
      $error("serial_port_regs: TRIG must lie in 1..DEPTH");
   end
   if (IRQ_W > BUS_W || LINE_W <= LINE_FIFO_EN) begin : g_bad_fields
      $error("serial_port_regs: field widths out of range");
   end
   if (CTRL_RST >= (1 << CTRL_W) || LEVEL_RST >= (1 << LEVEL_W)) begin : g_bad_rst
      $error("serial_port_regs: reset value does not fit its field");
   end

   // ---------------- decode ----------------
   logic [WORD_W-1:0] word;
   logic              id_hit;
   assign word   = bus_addr[ADDR_W-1:2];
   assign id_hit = &bus_addr[ADDR_W-1:5];

   function automatic logic hit(input logic [WORD_W-1:0] w, input logic [WORD_W-1:0] ofs);
      hit = (w == ofs);
   endfunction

   logic wr_data, wr_line, wr_mask, wr_clr, rd_data;
   assign wr_data = bus_wr && !id_hit && hit(word, OFS_DATA);
   assign wr_line = bus_wr && !id_hit && hit(word, OFS_LINE);
   assign wr_mask = bus_wr && !id_hit && hit(word, OFS_MASK);
   assign wr_clr  = bus_wr && !id_hit && hit(word, OFS_CLR);
   assign rd_data = bus_rd && !id_hit && hit(word, OFS_DATA);

   // ---------------- settings storage ----------------
   logic [LPDIV_W-1:0] lpdiv_q;
   logic [IBAUD_W-1:0] ibaud_q;
   logic [FBAUD_W-1:0] fbaud_q;
   logic [LINE_W-1:0]  line_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [LEVEL_W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpdiv_q <= '0;
         ibaud_q <= '0;
         fbaud_q <= '0;
         line_q  <= '0;
         ctrl_q  <= CTRL_W'(CTRL_RST);
         level_q <= LEVEL_W'(LEVEL_RST);
      end else if (bus_wr && !id_hit) begin
         if (hit(word, OFS_LPDIV)) lpdiv_q <= bus_wdata[LPDIV_W-1:0];
         if (hit(word, OFS_IBAUD)) ibaud_q <= bus_wdata[IBAUD_W-1:0];
         if (hit(word, OFS_FBAUD)) fbaud_q <= bus_wdata[FBAUD_W-1:0];
         if (wr_line)              line_q  <= bus_wdata[LINE_W-1:0];
         if (hit(word, OFS_CTRL))  ctrl_q  <= bus_wdata[CTRL_W-1:0];
         if (hit(word, OFS_LEVEL)) level_q <= bus_wdata[LEVEL_W-1:0];
      end
   end

   // ---------------- receive queue ----------------
   logic              fifo_en;
   logic [CNT_W-1:0]  rx_count;
   logic [CNT_W-1:0]  rx_cap;
   logic [7:0]        head;
   logic              rx_push, rx_pop_ok;

   assign fifo_en   = line_q[LINE_FIFO_EN];
   assign rx_cap    = fifo_en ? CAP_FIFO : CAP_ONE;
   assign rx_ready  = (rx_count < rx_cap);
   assign rx_push   = rx_valid && rx_ready;
   assign rx_pop_ok = rd_data && (rx_count != '0);

   sp_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (rx_data),
      .pop       (rd_data),
      .pop_data  (head),
      .count     (rx_count)
   );

   // ---------------- flags ----------------
   logic [7:0] flags;
   always_comb begin
      flags          = '0;
      flags[FLG_TXE] = 1'b1;
      flags[FLG_TXF] = 1'b0;
      flags[FLG_RXF] = (rx_count >= rx_cap);
      flags[FLG_RXE] = (rx_count == '0);
   end

   // ---------------- interrupts ----------------
   logic [IRQ_W-1:0] irq_set, irq_clr, irq_raw, irq_mask, irq_mis;
   logic             rx_reach, rx_drop;

   assign rx_reach = rx_push && !rx_pop_ok && (rx_count == TRIG_CNT - 1'b1);
   assign rx_drop  = rx_pop_ok && !rx_push && (rx_count == TRIG_CNT);

   always_comb begin
      irq_set         = '0;
      irq_set[IRQ_RX] = rx_reach;
      irq_set[IRQ_TX] = wr_data;
      irq_clr         = wr_clr ? bus_wdata[IRQ_W-1:0] : '0;
      irq_clr[IRQ_RX] = irq_clr[IRQ_RX] | rx_drop;
   end

   sp_irq_bank #(.W(IRQ_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (irq_set),
      .clr_vec    (irq_clr),
      .mask_we    (wr_mask),
      .mask_wdata (bus_wdata[IRQ_W-1:0]),
      .raw        (irq_raw),
      .mask       (irq_mask),
      .masked     (irq_mis),
      .irq        (irq)
   );

   // ---------------- transmit strobe ----------------
   assign tx_valid = wr_data;
   assign tx_data  = bus_wdata[7:0];

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (id_hit) begin
         bus_rdata = BUS_W'(id_byte(bus_addr[4:2]));
      end else begin
         case (word)
            OFS_DATA:  bus_rdata = BUS_W'(head);
            OFS_FLAG:  bus_rdata = BUS_W'(flags);
            OFS_LPDIV: bus_rdata = BUS_W'(lpdiv_q);
            OFS_IBAUD: bus_rdata = BUS_W'(ibaud_q);
            OFS_FBAUD: bus_rdata = BUS_W'(fbaud_q);
            OFS_LINE:  bus_rdata = BUS_W'(line_q);
            OFS_CTRL:  bus_rdata = BUS_W'(ctrl_q);
            OFS_LEVEL: bus_rdata = BUS_W'(level_q);
            OFS_MASK:  bus_rdata = BUS_W'(irq_mask);
            OFS_RAW:   bus_rdata = BUS_W'(irq_raw);
            OFS_MIS:   bus_rdata = BUS_W'(irq_mis);
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R7: a transmit strobe leaves the transmit raw bit set
   p_tx_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> irq_raw[IRQ_TX]);

   // R5: draining the last entry raises the receive-empty flag
   p_rx_empty_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop_ok && !rx_push && rx_count == CNT_W'(1)) |=> flags[FLG_RXE]);

   // R3: single-entry mode never holds a second character after an accept
   p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !wr_line && rx_push && !rx_pop_ok) |=> !rx_ready);
endmodule

// File: tb/serial_port_regs_tb.sv
module serial_port_regs_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_port_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_data = b; rx_valid = 1'b1;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   function automatic logic [7:0] seq_a(input int i);
      return 8'((i * 29 + 3) & 255);
   endfunction
   function automatic logic [7:0] seq_b(input int i);
      return 8'((i * 53 + 11) & 255);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  id_exp [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      logic [31:0] pat [2] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A};
      int          wid [6] = '{8, 16, 6, 8, 16, 6};

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_check("R1 flags", 12'h018, 32'h90);
      rd_check("R1 control", 12'h030, 32'h300);
      rd_check("R1 level", 12'h034, 32'h12);
      rd_check("R1 enable", 12'h038, 32'h0);
      @(negedge clk);
      check("R1 irq", 32'(irq), 32'h0);
      check("R1 rx_ready", 32'(rx_ready), 32'h1);

      // R9 identification sweep
      for (int i = 0; i < 8; i++)
         rd_check("R9 id", 12'(12'hFE0 + 4 * i), 32'(id_exp[i]));

      // R10 settings sweep
      for (int p = 0; p < 2; p++)
         for (int k = 0; k < 6; k++) begin
            wr(12'(12'h020 + 4 * k), pat[p]);
            rd_check("R10 readback", 12'(12'h020 + 4 * k), pat[p] & ((32'h1 << wid[k]) - 1));
         end
      rd_check("R10 unmapped", 12'h004, 32'h0);
      rd_check("R10 unmapped", 12'h01C, 32'h0);

      // FIFO mode
      wr(12'h02C, 32'h10);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         check("R2 ready below 16", 32'(rx_ready), 32'h1);
         push(seq_a(i));
         if (i == 0) rd_check("R6 rx raw set", 12'h03C, 32'h10);
      end
      @(negedge clk);
      check("R2 ready at 16", 32'(rx_ready), 32'h0);
      check("R8 irq masked off", 32'(irq), 32'h0);
      rd_check("R4 full flag", 12'h018, 32'hC0);
      push(8'hEE);
      for (int i = 0; i < 16; i++) begin
         rd_check("R5 pop order", 12'h000, 32'(seq_a(i)));
         if (i == 0) rd_check("R4 full cleared", 12'h018, 32'h80);
      end
      rd_check("R5 empty flag", 12'h018, 32'h90);
      rd_check("R6 rx raw cleared", 12'h03C, 32'h0);

      // R5 pop on empty
      rd(12'h000, v);
      rd_check("R5 empty pop flags", 12'h018, 32'h90);
      push(8'h3C);
      rd_check("R5 after empty pop", 12'h000, 32'h3C);

      // R2 wrap
      for (int i = 0; i < 10; i++) push(seq_b(i));
      for (int i = 0; i < 10; i++) rd_check("R2 partial", 12'h000, 32'(seq_b(i)));
      for (int i = 0; i < 16; i++) push(seq_b(i + 40));
      rd_check("R4 full after wrap", 12'h018, 32'hC0);
      for (int i = 0; i < 16; i++) rd_check("R2 wrap order", 12'h000, 32'(seq_b(i + 40)));

      // R3 single-entry mode
      wr(12'h02C, 32'h0);
      push(8'h5A);
      @(negedge clk);
      check("R3 ready held", 32'(rx_ready), 32'h0);
      rd_check("R4 full single", 12'h018, 32'hC0);
      push(8'h77);
      rd_check("R3 kept first", 12'h000, 32'h5A);
      rd_check("R3 dropped second", 12'h018, 32'h90);

      // R8 / R6 interrupts
      wr(12'h038, 32'h30);
      push(8'h42);
      rd_check("R8 masked rx", 12'h040, 32'h10);
      @(negedge clk);
      check("R8 irq on", 32'(irq), 32'h1);
      wr(12'h044, 32'h10);
      rd_check("R6 clear by write", 12'h03C, 32'h0);
      @(negedge clk);
      check("R8 irq off", 32'(irq), 32'h0);
      rd_check("R6 clear keeps data", 12'h018, 32'hC0);
      rd_check("R6 data", 12'h000, 32'h42);

      // R7 transmit
      @(negedge clk);
      bus_addr = 12'h000; bus_wdata = 32'h1A5; bus_wr = 1'b1;
      #1;
      check("R7 tx_valid", 32'(tx_valid), 32'h1);
      check("R7 tx_data", 32'(tx_data), 32'hA5);
      @(posedge clk); #1 bus_wr = 1'b0;
      rd_check("R7 tx raw", 12'h03C, 32'h20);
      rd_check("R8 masked tx", 12'h040, 32'h20);
      wr(12'h038, 32'h10);
      rd_check("R8 masked off", 12'h040, 32'h0);
      @(negedge clk);
      check("R8 irq masked", 32'(irq), 32'h0);
      wr(12'h044, 32'h20);
      rd_check("R8 w1c tx", 12'h03C, 32'h0);

      // R8 set wins over coincident clear
      @(negedge clk);
      rx_data = 8'h99; rx_valid = 1'b1;
      bus_addr = 12'h044; bus_wdata = 32'h10; bus_wr = 1'b1;
      @(posedge clk); #1;
      rx_valid = 1'b0; bus_wr = 1'b0;
      rd_check("R8 set wins", 12'h03C, 32'h10);
      rd_check("R6 pop data", 12'h000, 32'h99);
      rd_check("R6 pop clears", 12'h03C, 32'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule